// File: doc/BRIEF.md
# Two-Choice Random Victim Selector

This block picks which way of a cache set (or of a small fully associative cache) gets replaced on a miss. It does not search for a global minimum and does not take a single random pick. It draws two distinct candidate ways from an internal pseudo-random generator and evicts the weaker of the two. In frequency mode, the weaker candidate is the one with the lower saturating access count. In recency mode, it is the one that has gone untouched longer. It is meant to serve as the frequency-side half of a hybrid replacement scheme whose other half is a plain recency list.

The cache controller reports every hit and every fill on the touch port, giving the way index and marking fills. It raises a one-cycle request when it needs a victim. Ways not yet filled since reset are handed out first, before any random sampling. The answer comes back with a valid pulse exactly one cycle after the request. The generator advances only on requests, so the whole sequence of choices can be predicted from the event history.

Top module: `victim_sel`

## Requirements
- R1: `victim_valid_o` is high in the cycle after each cycle where `req_i` is high, and low otherwise. While reset is asserted (`rst_n` low), `victim_valid_o` is 0.
- R2: Reset marks every way invalid, and a fill marks its way valid. If any way is invalid when a request is sampled, the victim is the lowest-numbered invalid way. The generator still advances on that request.
- R3: The generator is a 16-bit register. It resets to 16'hACE1. On each request it steps to `{s[14:0], s[15]^s[13]^s[12]^s[10]}`. It holds its value in every cycle without a request.
- R4: The candidates come from the generator value before the step. Candidate A is `s[IDX_W-1:0]` and candidate B is `s[2*IDX_W-1:IDX_W]`, where IDX_W = log2(NUM_WAYS) and NUM_WAYS is a power of two. If B equals A, B becomes (A+1) mod NUM_WAYS.
- R5: With `mode_i`=0 (frequency), the victim is the candidate with the smaller access count. On equal counts, the lower-numbered candidate is chosen.
- R6: A fill sets its way's count to 1. A hit (touch with `touch_fill_i`=0) adds 1 to the count and saturates at 2^FREQ_W-1. A hit does not change the valid bit.
- R7: With `mode_i`=1 (recency), each way has an age. Any touch clears the touched way's age to 0 and adds 1 to every other way's age, saturating at 2^AGE_W-1. Reset clears all ages. The victim is the candidate with the larger age; on equal ages, the lower-numbered candidate is chosen.
- R8: A request is judged on the metadata held before a touch that arrives in the same cycle. That touch takes effect for later requests.
- R9: `mode_i` is sampled in the request cycle, and only then affects the choice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = compare by count, 1 = compare by age |
| touch_i | input | 1 | A hit or fill event on `touch_way_i` |
| touch_fill_i | input | 1 | The touch is a fill (1) or a hit (0) |
| touch_way_i | input | IDX_W | Way index of the touch |
| req_i | input | 1 | Victim request |
| victim_valid_o | output | 1 | Victim answer valid, one cycle after a request |
| victim_way_o | output | IDX_W | Chosen victim way |

## Verification
The bench builds the block with eight ways, a 3-bit count and a 3-bit age. With widths this narrow, both counters reach saturation after a handful of touches, so the capped values and the ties they create show up often. Eight ways use only six generator bits per request. Over a few thousand requests, the case where both candidates land on the same way comes up many times, along with wrap-around from way 7 to way 0. A behavioural model predicts every answer, including requests that coincide with touches and with mode changes.

// File: rtl/victim_sel_pkg.sv
package victim_sel_pkg;
    localparam int RNG_W = 16;
    localparam logic [RNG_W-1:0] RNG_SEED = 16'hACE1;

    typedef enum logic {
        CMP_FREQ    = 1'b0,
        CMP_RECENCY = 1'b1
    } cmp_mode_e;

    // maximal-length Fibonacci step, taps at bits 15,13,12,10
    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        return {s[RNG_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction
endpackage

// File: rtl/vs_rng.sv
module vs_rng
    import victim_sel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    output logic [RNG_W-1:0] state_o
);
    logic [RNG_W-1:0] state_d, state_q;

    always_comb begin
        state_d = step_i ? rng_step(state_q) : state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RNG_SEED;
        else        state_q <= state_d;
    end

    assign state_o = state_q;
endmodule

// File: rtl/vs_way_meta.sv
module vs_way_meta #(
    parameter int NUM_WAYS = 8,
    parameter int FREQ_W   = 3,
    parameter int AGE_W    = 3,
    localparam int IDX_W   = $clog2(NUM_WAYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             touch_i,
    input  logic                             fill_i,
    input  logic [IDX_W-1:0]                 way_i,
    output logic [NUM_WAYS-1:0]              valid_o,
    output logic [NUM_WAYS-1:0][FREQ_W-1:0]  freq_o,
    output logic [NUM_WAYS-1:0][AGE_W-1:0]   age_o
);
    localparam logic [FREQ_W-1:0] FREQ_MAX = {FREQ_W{1'b1}};
    localparam logic [AGE_W-1:0]  AGE_MAX  = {AGE_W{1'b1}};

    typedef struct packed {
        logic [NUM_WAYS-1:0]             valid;
        logic [NUM_WAYS-1:0][FREQ_W-1:0] freq;
        logic [NUM_WAYS-1:0][AGE_W-1:0]  age;
    } meta_t;

    meta_t meta_d, meta_q;

    always_comb begin
        meta_d = meta_q;
        if (touch_i) begin
            for (int i = 0; i < NUM_WAYS; i++) begin
                if (way_i == IDX_W'(i)) begin
                    meta_d.age[i] = '0;
                    if (fill_i) begin
                        meta_d.valid[i] = 1'b1;
                        meta_d.freq[i]  = FREQ_W'(1);
                    end else if (meta_q.freq[i] != FREQ_MAX) begin
                        meta_d.freq[i] = meta_q.freq[i] + FREQ_W'(1);
                    end
                end else if (meta_q.age[i] != AGE_MAX) begin
                    meta_d.age[i] = meta_q.age[i] + AGE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) meta_q <= '0;
        else        meta_q <= meta_d;
    end

    assign valid_o = meta_q.valid;
    assign freq_o  = meta_q.freq;
    assign age_o   = meta_q.age;
endmodule

// File: rtl/vs_pick.sv
module vs_pick
    import victim_sel_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int FREQ_W   = 3,
    parameter int AGE_W    = 3,
    localparam int IDX_W   = $clog2(NUM_WAYS)
) (
    input  cmp_mode_e                        mode_i,
    input  logic [RNG_W-1:0]                 rng_i,
    input  logic [NUM_WAYS-1:0]              valid_i,
    input  logic [NUM_WAYS-1:0][FREQ_W-1:0]  freq_i,
    input  logic [NUM_WAYS-1:0][AGE_W-1:0]   age_i,
    output logic [IDX_W-1:0]                 way_o
);
    logic [IDX_W-1:0] cand_a, cand_b, raw_b, first_free;
    logic             any_free, take_b;

    always_comb begin
        cand_a = rng_i[IDX_W-1:0];
        raw_b  = rng_i[2*IDX_W-1:IDX_W];
        cand_b = (raw_b == cand_a) ? cand_a + IDX_W'(1) : raw_b;

        any_free   = 1'b0;
        first_free = '0;
        for (int i = NUM_WAYS - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                any_free   = 1'b1;
                first_free = IDX_W'(i);
            end
        end

        if (mode_i == CMP_FREQ) begin
            take_b = (freq_i[cand_b] < freq_i[cand_a]) ||
                     ((freq_i[cand_b] == freq_i[cand_a]) && (cand_b < cand_a));
        end else begin
            take_b = (age_i[cand_b] > age_i[cand_a]) ||
                     ((age_i[cand_b] == age_i[cand_a]) && (cand_b < cand_a));
        end

        if (any_free)    way_o = first_free;
        else if (take_b) way_o = cand_b;
        else             way_o = cand_a;
    end
endmodule

// File: rtl/victim_sel.sv
module victim_sel
    import victim_sel_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    parameter int FREQ_W   = 3,
    parameter int AGE_W    = 3,
    localparam int IDX_W   = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             touch_i,
    input  logic             touch_fill_i,
    input  logic [IDX_W-1:0] touch_way_i,
    input  logic             req_i,
    output logic             victim_valid_o,
    output logic [IDX_W-1:0] victim_way_o
);
    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] way;
    } resp_t;

    resp_t resp_d, resp_q;

    logic [RNG_W-1:0]                rng_state;
    logic [NUM_WAYS-1:0]             way_valid;
    logic [NUM_WAYS-1:0][FREQ_W-1:0] way_freq;
    logic [NUM_WAYS-1:0][AGE_W-1:0]  way_age;
    logic [IDX_W-1:0]                pick_way;
    cmp_mode_e                       cmp_mode;

    assign cmp_mode = cmp_mode_e'(mode_i);

    vs_rng u_rng (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (req_i),
        .state_o (rng_state)
    );

    vs_way_meta #(.NUM_WAYS(NUM_WAYS), .FREQ_W(FREQ_W), .AGE_W(AGE_W)) u_meta (
        .clk     (clk),
        .rst_n   (rst_n),
        .touch_i (touch_i),
        .fill_i  (touch_fill_i),
        .way_i   (touch_way_i),
        .valid_o (way_valid),
        .freq_o  (way_freq),
        .age_o   (way_age)
    );

    vs_pick #(.NUM_WAYS(NUM_WAYS), .FREQ_W(FREQ_W), .AGE_W(AGE_W)) u_pick (
        .mode_i  (cmp_mode),
        .rng_i   (rng_state),
        .valid_i (way_valid),
        .freq_i  (way_freq),
        .age_i   (way_age),
        .way_o   (pick_way)
    );

    always_comb begin
        resp_d.valid = req_i;
        resp_d.way   = req_i ? pick_way : resp_q.way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign victim_valid_o = resp_q.valid;
    assign victim_way_o   = resp_q.way;
endmodule

// File: rtl/victim_sel_chk.sv
module victim_sel_chk
    import victim_sel_pkg::*;
#(
    parameter int NUM_WAYS = 8,
    localparam int IDX_W   = $clog2(NUM_WAYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_i,
    input logic                victim_valid_o,
    input logic [IDX_W-1:0]    victim_way_o,
    input logic [RNG_W-1:0]    rng_q,
    input logic [NUM_WAYS-1:0] valid_q
);
    logic [NUM_WAYS-1:0] victim_bit;
    always_comb victim_bit = NUM_WAYS'(1) << victim_way_o;

    p_pulse_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> victim_valid_o);

    p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !victim_valid_o);

    p_rng_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> $stable(rng_q));

    p_rng_moves_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> !$stable(rng_q));

    p_rng_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rng_q != '0);

    p_free_way_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !(&valid_q)) |=> (($past(valid_q) & victim_bit) == '0));
endmodule

bind victim_sel victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_i          (req_i),
    .victim_valid_o (victim_valid_o),
    .victim_way_o   (victim_way_o),
    .rng_q          (rng_state),
    .valid_q        (way_valid)
);

// File: tb/victim_sel_test.sv
`timescale 1ns/1ps
module victim_sel_test;
    localparam int NW    = 8;
    localparam int FW    = 3;
    localparam int AW    = 3;
    localparam int IW    = $clog2(NW);
    localparam int FMAX  = (1 << FW) - 1;
    localparam int AMAX  = (1 << AW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_i = 1'b0, touch_i = 1'b0, touch_fill_i = 1'b0, req_i = 1'b0;
    logic [IW-1:0] touch_way_i = '0;
    logic victim_valid_o;
    logic [IW-1:0] victim_way_o;

    always #2.5 clk = ~clk;

    victim_sel #(.NUM_WAYS(NW), .FREQ_W(FW), .AGE_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .touch_i(touch_i),
        .touch_fill_i(touch_fill_i), .touch_way_i(touch_way_i), .req_i(req_i),
        .victim_valid_o(victim_valid_o), .victim_way_o(victim_way_o)
    );

    // reference model
    int  m_freq[NW];
    int  m_age[NW];
    bit  m_valid[NW];
    int  m_rng;
    bit  exp_valid = 0;
    int  exp_way = 0;
    int  n_checks = 0, n_fail = 0;
    bit  done = 0;
    string tag = "R1";

    function automatic int pick_model();
        int a, b;
        for (int i = 0; i < NW; i++) if (!m_valid[i]) return i;
        a = m_rng % NW;
        b = (m_rng / NW) % NW;
        if (b == a) b = (a + 1) % NW;                    // R4
        if (mode_i == 1'b0) begin                         // R5
            if (m_freq[b] < m_freq[a] || (m_freq[b] == m_freq[a] && b < a)) return b;
            return a;
        end
        if (m_age[b] > m_age[a] || (m_age[b] == m_age[a] && b < a)) return b;  // R7
        return a;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) begin
                m_freq[i] = 0; m_age[i] = 0; m_valid[i] = 0;
            end
            m_rng = 16'hACE1;
            exp_valid = 0;
        end else begin
            if (req_i) begin                              // R8: judged before touch
                exp_valid = 1;
                exp_way = pick_model();
                m_rng = ((m_rng << 1) & 16'hFFFF) |
                        (((m_rng >> 15) ^ (m_rng >> 13) ^ (m_rng >> 12) ^ (m_rng >> 10)) & 1);
            end else begin
                exp_valid = 0;
            end
            if (touch_i) begin                            // R6, R7
                for (int i = 0; i < NW; i++) begin
                    if (i == int'(touch_way_i)) begin
                        m_age[i] = 0;
                        if (touch_fill_i) begin m_valid[i] = 1; m_freq[i] = 1; end
                        else if (m_freq[i] < FMAX) m_freq[i]++;
                    end else if (m_age[i] < AMAX) m_age[i]++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (victim_valid_o !== exp_valid) begin
                n_fail++;
                $display("FAIL %s valid: actual %b expected %b at %0t", tag, victim_valid_o, exp_valid, $time);
            end
            if (exp_valid) begin
                n_checks++;
                if (int'(victim_way_o) !== exp_way) begin
                    n_fail++;
                    $display("FAIL %s way: actual %0d expected %0d at %0t", tag, victim_way_o, exp_way, $time);
                end
            end
        end
    end

    task automatic cyc(input bit rq, input bit md, input bit tv, input int tw, input bit tf);
        @(negedge clk);
        req_i = rq; mode_i = md; touch_i = tv; touch_way_i = IW'(tw); touch_fill_i = tf;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(150000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0);
        tag = "R2";                                      // free ways first
        cyc(1, 0, 0, 0, 0);
        cyc(1, 1, 0, 0, 0);
        for (int w = 0; w < 3; w++) cyc(0, 0, 1, w, 1);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 0, 1, 5, 1);
        cyc(1, 0, 0, 0, 0);
        for (int w = 3; w < NW; w++) cyc(0, 0, 1, w, 1);
        tag = "R6";                                      // counts, saturation
        for (int k = 0; k < 12; k++) cyc(0, 0, 1, 5, 0);
        for (int k = 0; k < 3; k++) cyc(0, 0, 1, 1, 0);
        cyc(0, 0, 1, 6, 0);
        tag = "R3/R4/R5";                                // frequency mode sequence
        for (int k = 0; k < 40; k++) cyc(1, 0, (k % 3) == 0, (k * 3) % NW, 0);
        tag = "R7/R9";                                   // recency mode, mode flips
        for (int k = 0; k < 40; k++) cyc(1, (k % 5) != 0, 1, (k * 5) % NW, 0);
        tag = "R8";                                      // request with touch same cycle
        for (int k = 0; k < 20; k++) cyc(1, k[0], 1, k % NW, k % 4 == 0);
        tag = "R4/R5/R6/R7";                             // random mix
        for (int k = 0; k < 4000; k++)
            cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, NW - 1), $urandom_range(0, 9) == 0);
        tag = "R1";
        cyc(0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule